// File: doc/BRIEF.md
# Microsecond Timing-Sync Counter

This block keeps a 64-bit free-running time base for a wireless MAC, counted in microseconds. A one-cycle strobe arriving once per microsecond advances it by one. Other logic sees the whole count on a 64-bit output bus. Software reaches the counter through a plain 32-bit register port that has separate write and read sides.

To preload the counter, software first stages a low word. It then writes the high load register twice: once with the top bit set, then again with the top bit clear. The counter is loaded only on that 1-to-0 change of the top bit, so both halves land at the same instant. A separate clear register forces the counter to zero.

Reading the live low half also captures the live high half into a shadow register. A later read of the high half returns that shadow, so a carry between the two reads cannot split the value.

Top module: `tsf_timer`

## Requirements
- R1: After reset, `tsfValue` and `rdData` are zero.
- R2: With no write pending, each cycle with `tick` high advances `tsfValue` by exactly one on the next edge, carrying across bit 31 into bit 32. A cycle with `tick` low leaves it unchanged.
- R3: A write to address 0 (low load word) only stages the data. `tsfValue` keeps advancing as in R2.
- R4: A write to address 1 (high load word) with data bit 31 at 0 reloads the counter, provided the previous write to address 1 had bit 31 at 1. On the next edge `tsfValue` becomes {1'b0, data[30:0], staged low word}.
- R5: A write to address 1 with bit 31 at 1 never reloads. A write with bit 31 at 0 whose previous address-1 write also had bit 31 at 0 never reloads. Neither write affects counting.
- R6: A read with `rdAddr` 0 puts the live `tsfValue[31:0]` on `rdData` one cycle later. The same read captures the live `tsfValue[63:32]` into a shadow.
- R7: A read with `rdAddr` 1 puts the shadow from the most recent address-0 read on `rdData` one cycle later, whatever ticks occurred since. Any other read address returns zero. With `rdEn` low, `rdData` holds.
- R8: A write to address 2 (clear) makes `tsfValue` zero on the next edge.
- R9: When a reload and a tick fall in the same cycle, the loaded value is taken exactly and the tick is dropped.
- R10: A clear wins over a reload or a tick pending in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-microsecond advance strobe |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address: 0 low load, 1 high load, 2 clear |
| wrData | input | WORD_W | Write data |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | ADDR_W | Read address: 0 live low, 1 shadowed high |
| rdData | output | WORD_W | Registered read data |
| tsfValue | output | 2*WORD_W | Live counter value |

## Verification
Every result here comes out of a single register stage. A tick, reload or clear shows on `tsfValue` at the first rising edge after the cycle that carries it. Read data appears on `rdData` at that same edge.

The bench applies inputs on the falling edge. It advances its behavioural model at the rising edge, using the inputs that were held across it. It compares both outputs at the next falling edge, so every check samples exactly one edge after its stimulus. Same-cycle collisions of tick, reload and clear are driven directly, so their priority is observed on that one edge.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  // write map
  localparam int ADDR_LOAD_LO = 0;
  localparam int ADDR_LOAD_HI = 1;
  localparam int ADDR_CLEAR   = 2;
  // read map
  localparam int ADDR_LIVE_LO = 0;
  localparam int ADDR_LIVE_HI = 1;

  typedef struct packed {
    logic stageLo;
    logic reload;
    logic clear;
    logic rdLo;
    logic rdHi;
    logic rdAny;
  } tsfStrobes_t;
endpackage

// File: rtl/tsf_ctrl.sv
module tsf_ctrl
  import tsf_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrMsb,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output tsfStrobes_t       strb
);
  logic hiMsbQ;
  logic hiWrite;

  assign hiWrite = wrEn && (wrAddr == ADDR_W'(ADDR_LOAD_HI));

  // remembers the top bit of the last high-word write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hiMsbQ <= 1'b0;
    else if (hiWrite) hiMsbQ <= wrMsb;
  end

  always_comb begin
    strb.stageLo = wrEn && (wrAddr == ADDR_W'(ADDR_LOAD_LO));
    strb.clear   = wrEn && (wrAddr == ADDR_W'(ADDR_CLEAR));
    strb.reload  = hiWrite && hiMsbQ && !wrMsb;
    strb.rdLo    = rdEn && (rdAddr == ADDR_W'(ADDR_LIVE_LO));
    strb.rdHi    = rdEn && (rdAddr == ADDR_W'(ADDR_LIVE_HI));
    strb.rdAny   = rdEn;
  end
endmodule

// File: rtl/tsf_datapath.sv
module tsf_datapath
  import tsf_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  tsfStrobes_t         strb,
  input  logic [WORD_W-1:0]   wrWord,
  output logic [WORD_W-1:0]   rdData,
  output logic [2*WORD_W-1:0] count
);
  localparam int TIMER_W = 2 * WORD_W;

  logic [WORD_W-1:0]  stageLo;
  logic [WORD_W-1:0]  shadowHi;
  logic [TIMER_W-1:0] loadVal;

  // the commit write supplies bits 62:32, bit 63 is forced low
  assign loadVal = {1'b0, wrWord[WORD_W-2:0], stageLo};

  // clear > reload > tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (strb.clear)  count <= '0;
    else if (strb.reload) count <= loadVal;
    else if (tick)        count <= count + TIMER_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageLo <= '0;
    else if (strb.stageLo) stageLo <= wrWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowHi <= '0;
    else if (strb.rdLo) shadowHi <= count[TIMER_W-1:WORD_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strb.rdAny) begin
      if (strb.rdLo)      rdData <= count[WORD_W-1:0];
      else if (strb.rdHi) rdData <= shadowHi;
      else                rdData <= '0;
    end
  end
endmodule

// File: rtl/tsf_timer.sv
module tsf_timer
  import tsf_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [WORD_W-1:0]   wrData,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [WORD_W-1:0]   rdData,
  output logic [2*WORD_W-1:0] tsfValue
);
  tsfStrobes_t strb;

  tsf_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrMsb(wrData[WORD_W-1]), .rdEn(rdEn), .rdAddr(rdAddr), .strb(strb)
  );

  tsf_datapath #(.WORD_W(WORD_W)) uData (
    .clk(clk), .rstN(rstN), .tick(tick), .strb(strb),
    .wrWord(wrData), .rdData(rdData), .count(tsfValue)
  );
endmodule

// File: rtl/tsf_timer_chk.sv
module tsf_timer_chk #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                tick,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   wrAddr,
  input logic [WORD_W-1:0]   wrData,
  input logic                rdEn,
  input logic [ADDR_W-1:0]   rdAddr,
  input logic [WORD_W-1:0]   rdData,
  input logic [2*WORD_W-1:0] tsfValue
);
  localparam int TW = 2 * WORD_W;

  logic [WORD_W-1:0] lastLo;
  logic              lastMsb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastLo  <= '0;
      lastMsb <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_W'(0)) lastLo <= wrData;
      if (wrAddr == ADDR_W'(1)) lastMsb <= wrData[WORD_W-1];
    end
  end

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && tick) |=> tsfValue == $past(tsfValue) + TW'(1));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !tick) |=> $stable(tsfValue));

  // R3
  lo_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(0) && !tick) |=> $stable(tsfValue));

  // R4
  reload_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(1) && !wrData[WORD_W-1] && lastMsb) |=>
      tsfValue == {1'b0, $past(wrData[WORD_W-2:0]), $past(lastLo)});

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(2)) |=> tsfValue == '0);

  // R6
  read_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == ADDR_W'(0)) |=> rdData == $past(tsfValue[WORD_W-1:0]));

  // R7
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
endmodule

bind tsf_timer tsf_timer_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
  .tsfValue(tsfValue)
);

// File: tb/tsf_timer_test.sv
module tsf_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [63:0] tsfValue;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";

  // behavioural reference state
  logic [63:0] mCount = '0;
  logic [31:0] mLo = '0;
  logic        mMsb = 1'b0;
  logic [31:0] mShadow = '0;
  logic [31:0] mRd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsf_timer uut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .tsfValue(tsfValue)
  );

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelStep();
    logic [63:0] nCount;
    nCount = mCount;
    if (rdEn) begin
      if (rdAddr == 3'd0) begin
        mRd = mCount[31:0];
        mShadow = mCount[63:32];
      end else if (rdAddr == 3'd1) mRd = mShadow;
      else mRd = '0;
    end
    if (wrEn && wrAddr == 3'd2) nCount = '0;
    else if (wrEn && wrAddr == 3'd1 && !wrData[31] && mMsb)
      nCount = {1'b0, wrData[30:0], mLo};
    else if (tick) nCount = mCount + 64'd1;
    if (wrEn && wrAddr == 3'd0) mLo = wrData;
    if (wrEn && wrAddr == 3'd1) mMsb = wrData[31];
    mCount = nCount;
  endtask

  // one clock: inputs set at negedge, model at posedge, compare at next negedge
  task automatic cyc(logic w, logic [2:0] wa, logic [31:0] wd,
                     logic r, logic [2:0] ra, logic tk);
    wrEn = w; wrAddr = wa; wrData = wd; rdEn = r; rdAddr = ra; tick = tk;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check64({curReq, " tsfValue"}, tsfValue, mCount);
    check64({curReq, " rdData"}, {32'd0, rdData}, {32'd0, mRd});
  endtask

  task automatic idle(int n, logic tk);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 32'd0, 1'b0, 3'd0, tk);
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    check64("R1 reset tsfValue", tsfValue, 64'd0);
    check64("R1 reset rdData", {32'd0, rdData}, 64'd0);
    rstN = 1'b1;

    curReq = "R2";
    idle(5, 1'b1);
    idle(3, 1'b0);
    for (int i = 0; i < 8; i++) cyc(1'b0, 3'd0, 32'd0, 1'b0, 3'd0, i[0]);
    check64("R2 after ticks", tsfValue, 64'd9);

    curReq = "R3";
    cyc(1'b1, 3'd0, 32'hDEADBEEF, 1'b0, 3'd0, 1'b1);
    cyc(1'b1, 3'd0, 32'hDEADBEEF, 1'b0, 3'd0, 1'b0);
    check64("R3 low stage no effect", tsfValue, 64'd10);

    curReq = "R5";
    cyc(1'b1, 3'd1, 32'h0000_0005, 1'b0, 3'd0, 1'b0);
    check64("R5 msb low without prior high", tsfValue, 64'd10);
    cyc(1'b1, 3'd1, 32'h8000_0012, 1'b0, 3'd0, 1'b1);
    check64("R5 msb set alone", tsfValue, 64'd11);

    curReq = "R4";
    cyc(1'b1, 3'd1, 32'h0000_0012, 1'b0, 3'd0, 1'b0);
    check64("R4 reload value", tsfValue, 64'h0000_0012_DEADBEEF);
    idle(4, 1'b1);
    cyc(1'b1, 3'd1, 32'h0000_0033, 1'b0, 3'd0, 1'b0);
    check64("R5 second low write no reload", tsfValue, 64'h0000_0012_DEADBEF3);

    curReq = "R9";
    cyc(1'b1, 3'd0, 32'hFFFF_FFFE, 1'b0, 3'd0, 1'b0);
    cyc(1'b1, 3'd1, 32'hFFFF_FFFF, 1'b0, 3'd0, 1'b0);
    cyc(1'b1, 3'd1, 32'h7FFF_FFFF, 1'b0, 3'd0, 1'b1);
    check64("R9 reload beats tick, bit63 low", tsfValue, 64'h7FFF_FFFF_FFFF_FFFE);
    curReq = "R2";
    idle(3, 1'b1);
    check64("R2 carry across words", tsfValue, 64'h8000_0000_0000_0001);

    curReq = "R6";
    cyc(1'b1, 3'd0, 32'hFFFF_FFFF, 1'b0, 3'd0, 1'b0);
    cyc(1'b1, 3'd1, 32'h8000_0004, 1'b0, 3'd0, 1'b0);
    cyc(1'b1, 3'd1, 32'h0000_0004, 1'b0, 3'd0, 1'b0);
    cyc(1'b0, 3'd0, 32'd0, 1'b1, 3'd0, 1'b1);
    check64("R6 low read", {32'd0, rdData}, 64'h0000_0000_FFFF_FFFF);
    curReq = "R7";
    idle(2, 1'b1);
    check64("R7 rdData holds", {32'd0, rdData}, 64'h0000_0000_FFFF_FFFF);
    cyc(1'b0, 3'd0, 32'd0, 1'b1, 3'd1, 1'b0);
    check64("R7 shadow survives carry", {32'd0, rdData}, 64'h0000_0000_0000_0004);
    cyc(1'b0, 3'd0, 32'd0, 1'b1, 3'd5, 1'b0);
    check64("R7 unmapped read zero", {32'd0, rdData}, 64'd0);
    cyc(1'b0, 3'd0, 32'd0, 1'b1, 3'd0, 1'b0);
    cyc(1'b0, 3'd0, 32'd0, 1'b1, 3'd1, 1'b0);
    check64("R7 shadow high", {32'd0, rdData}, 64'h0000_0000_0000_0005);

    curReq = "R8";
    cyc(1'b1, 3'd2, 32'd0, 1'b0, 3'd0, 1'b1);
    check64("R8 clear", tsfValue, 64'd0);
    idle(3, 1'b1);

    curReq = "R10";
    cyc(1'b1, 3'd1, 32'h8000_0001, 1'b0, 3'd0, 1'b0);
    cyc(1'b1, 3'd2, 32'h0000_0001, 1'b0, 3'd0, 1'b1);
    check64("R10 clear beats tick", tsfValue, 64'd0);
    idle(2, 1'b1);
    check64("R10 counting resumes", tsfValue, 64'd2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule